// File: doc/BRIEF.md
# Queued Asynchronous Serial Transmitter with Nine-Bit Characters

This block turns a stream of bytes into asynchronous serial frames on a single output line. Bytes are offered on a valid/ready write port and held in an internal queue. Whenever the frame shifter is free, it takes the next character from the queue and sends it: a low start bit, the data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. Each bit lasts a programmable number of system clock cycles.

A character has 7, 8 or 9 data bits. Parity, even or odd, can be added to 7-bit and 8-bit characters. It is never added to 9-bit characters. A 9-bit character normally carries a zero in its top bit. In paired mode, two queued bytes make one character: the first byte gives the low eight bits, and bit 0 of the second byte gives the top bit. The line settings sit in a configuration register that is written with a one-cycle strobe. After reset, this register holds 8 data bits, no parity, one stop bit, and the divisor that gives 9600 bit/s at the configured clock rate.

Top module: `uart_fifo_tx`

## Requirements
- R1: After reset, `tx` is high, `busy` is low and `wr_ready` is high. Whenever no frame is being sent, `tx` stays high.
- R2: A frame is sent in this order: a low start bit, then the data bits with the least significant bit first, then the parity bit when it is used, then the high stop bit or bits. After reset the format is 8 data bits, no parity and one stop bit.
- R3: The width code in `cfg_width` is 0 for 7 bits, 1 for 8 bits and 2 for 9 bits. Code 3 acts like code 1.
- R4: When `cfg_par_en` is 1 and the width is 7 or 8 bits, a parity bit follows the data. With `cfg_par_odd` = 0, the data bits and the parity bit together hold an even number of ones. With `cfg_par_odd` = 1, they hold an odd number. In 7-bit mode, bit 7 of the byte is ignored.
- R5: `cfg_stop2` = 1 sends two stop bits. `cfg_stop2` = 0 sends one.
- R6: In 9-bit mode with `cfg_wide` = 0, each byte is one character and data bit 8 is always 0. No parity bit is sent, even when `cfg_par_en` is 1.
- R7: In 9-bit mode with `cfg_wide` = 1, two queued bytes make one 11-bit frame. The first byte gives data bits 7..0, and bit 0 of the second byte gives data bit 8. Bits 7..1 of the second byte are ignored.
- R8: In paired mode, no frame starts until both bytes of a character are in the queue. While only one byte waits, `tx` stays high.
- R9: Every bit lasts exactly `cfg_div` clock cycles. A divisor of 0 acts like 1. After reset, the divisor is round(CLK_HZ/BAUD).
- R10: When another character is ready as the last stop bit ends, its start bit follows with no idle cycle.
- R11: The queue holds DEPTH bytes. `wr_ready` is low only while the queue is full.
- R12: `busy` is high while the queue holds any byte or a frame is being sent. It goes low once the last stop bit has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | One-cycle strobe that loads the line settings below |
| cfg_div | input | DIV_W | Bit period in clock cycles |
| cfg_width | input | 2 | Data width code: 0 = 7, 1 = 8, 2 = 9 bits |
| cfg_par_en | input | 1 | Add a parity bit (7-bit and 8-bit only) |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | 1 = two stop bits |
| cfg_wide | input | 1 | Build each 9-bit character from two bytes |
| wr_valid | input | 1 | Write byte offered |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Queue can accept a byte |
| tx | output | 1 | Serial line, idles high |
| busy | output | 1 | Queue not empty or frame in progress |

## Verification
The bench sets CLK_HZ to 96000 and BAUD to 9600, which gives a reset divisor of 10. This makes the power-on format testable within the cycle budget: a default frame takes 100 cycles instead of tens of thousands. DEPTH keeps its value of 128. A long divisor in the last scenario holds the first character in the shifter while the queue fills, so the full-queue boundary is reached after exactly DEPTH+1 accepted bytes. The other scenarios use short divisors of 5 to 13 cycles. These make it cheap to time single bit periods and back-to-back frame spacing, and to run each width, parity and paired-mode case.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

   typedef enum logic [1:0] {
      WID_7 = 2'd0,
      WID_8 = 2'd1,
      WID_9 = 2'd2
   } width_e;

   typedef struct packed {
      width_e width;
      logic   par_en;
      logic   par_odd;
      logic   stop2;
      logic   wide;
   } line_fmt_t;

   localparam line_fmt_t FMT_RESET = '{width: WID_8, par_en: 1'b0, par_odd: 1'b0,
                                       stop2: 1'b0, wide: 1'b0};

   function automatic width_e decode_width(input logic [1:0] code);
      case (code)
         2'd0:    return WID_7;
         2'd2:    return WID_9;
         default: return WID_8;
      endcase
   endfunction

endpackage

// File: rtl/uftx_fifo.sv
module uftx_fifo #(
   parameter int DEPTH = 128,
   parameter int W     = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         push,
   input  logic [W-1:0]                 din,
   input  logic                         pop_one,
   input  logic                         pop_two,
   output logic                         full,
   output logic [W-1:0]                 head,
   output logic [W-1:0]                 second,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW   = $clog2(DEPTH+1);
   localparam bit POW2 = (DEPTH == (1 << AW));

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("uftx_fifo: DEPTH must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("uftx_fifo: W must be positive");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW-1:0] wr_p1, rd_p1, rd_p2;

   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_p1 = wr_ptr + AW'(1);
         assign rd_p1 = rd_ptr + AW'(1);
         assign rd_p2 = rd_ptr + AW'(2);
      end else begin : g_wrap_mod
         assign wr_p1 = (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
         assign rd_p1 = (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
         assign rd_p2 = (rd_ptr >= AW'(DEPTH-2)) ? AW'(rd_ptr - AW'(DEPTH-2))
                                                  : rd_ptr + AW'(2);
      end
   endgenerate

   assign full   = (count == CW'(DEPTH));
   assign head   = mem[rd_ptr];
   assign second = mem[rd_p1];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_p1;
         if (pop_two)      rd_ptr <= rd_p2;
         else if (pop_one) rd_ptr <= rd_p1;
         count <= count + CW'(push) - (pop_two ? CW'(2) : CW'(pop_one));
      end
   end

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (count < CW'(DEPTH)));
   assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
   assert_pair_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pop_two |-> (count >= CW'(2)));
   assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pop_one |-> (count != '0));
endmodule

// File: rtl/uftx_shifter.sv
module uftx_shifter
   import uftx_pkg::*;
#(
   parameter int DIV_W   = 16,
   parameter int FRAME_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  line_fmt_t        fmt,
   input  logic             load,
   input  logic [8:0]       data9,
   output logic             tx,
   output logic             active,
   output logic             free
);
   localparam int LEN_W = $clog2(FRAME_W + 1);

   generate
      if (FRAME_W < 13) begin : g_bad_frame
         $error("uftx_shifter: FRAME_W must hold start, 9 data, parity and 2 stop bits");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("uftx_shifter: DIV_W must be positive");
      end
   endgenerate

   logic [FRAME_W-1:0] sreg, frame;
   logic [LEN_W-1:0]   bits_left, flen;
   logic [DIV_W-1:0]   cnt, div_m1;
   logic               last;

   // Build the whole frame from the current format when a character is taken.
   always_comb begin
      int  nd;
      logic use_par;
      logic [7:0] pmask;
      nd      = (fmt.width == WID_7) ? 7 : (fmt.width == WID_9) ? 9 : 8;
      use_par = fmt.par_en && (fmt.width != WID_9);
      pmask   = (fmt.width == WID_7) ? 8'h7F : 8'hFF;
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < 9; i++) begin
         if (i < nd) frame[1+i] = data9[i];
      end
      if (use_par) frame[1+nd] = fmt.par_odd ^ (^(data9[7:0] & pmask));
      flen = LEN_W'(2 + nd + (use_par ? 1 : 0) + (fmt.stop2 ? 1 : 0));
   end

   assign div_m1 = (div == '0) ? '0 : div - DIV_W'(1);
   assign last   = active && (cnt == '0) && (bits_left == '0);
   assign free   = !active || last;
   assign tx     = sreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg      <= '1;
         bits_left <= '0;
         cnt       <= '0;
         active    <= 1'b0;
      end else if (load) begin
         sreg      <= frame;
         bits_left <= flen - LEN_W'(1);
         cnt       <= div_m1;
         active    <= 1'b1;
      end else if (active) begin
         if (cnt == '0) begin
            if (bits_left == '0) begin
               active <= 1'b0;
               sreg   <= '1;
            end else begin
               sreg      <= {1'b1, sreg[FRAME_W-1:1]};
               bits_left <= bits_left - LEN_W'(1);
               cnt       <= div_m1;
            end
         end else begin
            cnt <= cnt - DIV_W'(1);
         end
      end
   end

   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> tx);
   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !tx);
   assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      last |-> tx);
   assert_load_when_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> free);
endmodule

// File: rtl/uart_fifo_tx.sv
module uart_fifo_tx
   import uftx_pkg::*;
#(
   parameter int CLK_HZ = 50_000_000,
   parameter int BAUD   = 9600,
   parameter int DIV_W  = 16,
   parameter int DEPTH  = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [1:0]       cfg_width,
   input  logic             cfg_par_en,
   input  logic             cfg_par_odd,
   input  logic             cfg_stop2,
   input  logic             cfg_wide,
   input  logic             wr_valid,
   input  logic [7:0]       wr_data,
   output logic             wr_ready,
   output logic             tx,
   output logic             busy
);
   localparam int RESET_DIV = (CLK_HZ + BAUD / 2) / BAUD;
   localparam int CW        = $clog2(DEPTH + 1);

   generate
      if (BAUD < 1 || RESET_DIV < 1) begin : g_bad_rate
         $error("uart_fifo_tx: CLK_HZ/BAUD must give a divisor of at least 1");
      end
      if (RESET_DIV >= (64'd1 << DIV_W)) begin : g_div_range
         $error("uart_fifo_tx: reset divisor does not fit in DIV_W bits");
      end
   endgenerate

   line_fmt_t        fmt_q;
   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q <= FMT_RESET;
         div_q <= DIV_W'(RESET_DIV);
      end else if (cfg_wr) begin
         fmt_q <= '{width: decode_width(cfg_width), par_en: cfg_par_en,
                    par_odd: cfg_par_odd, stop2: cfg_stop2, wide: cfg_wide};
         div_q <= cfg_div;
      end
   end

   logic          full, push, pop_one, pop_two, load, avail, wide9, active, free;
   logic [7:0]    head, second;
   logic [CW-1:0] count;
   logic [8:0]    data9;

   assign wr_ready = !full;
   assign push     = wr_valid && !full;
   assign wide9    = fmt_q.wide && (fmt_q.width == WID_9);
   assign avail    = wide9 ? (count >= CW'(2)) : (count != '0);
   assign load     = free && avail;
   assign pop_one  = load && !wide9;
   assign pop_two  = load && wide9;
   assign data9    = {wide9 ? second[0] : 1'b0, head};
   assign busy     = (count != '0) || active;

   uftx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (push),
      .din     (wr_data),
      .pop_one (pop_one),
      .pop_two (pop_two),
      .full    (full),
      .head    (head),
      .second  (second),
      .count   (count)
   );

   uftx_shifter #(.DIV_W(DIV_W), .FRAME_W(13)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .div    (div_q),
      .fmt    (fmt_q),
      .load   (load),
      .data9  (data9),
      .tx     (tx),
      .active (active),
      .free   (free)
   );

   assert_busy_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> tx);
   assert_half_pair_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wide9 && count == CW'(1) && !active) |=> tx);
   assert_full_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CW'(DEPTH)) |-> !wr_ready);
endmodule

// File: tb/test_uart_fifo_tx.sv
`timescale 1ns/1ps
module test_uart_fifo_tx;
   localparam int DIV_W = 16;
   localparam int DEPTH = 128;
   localparam int TCK   = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_wr = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_stop2 = 1'b0, cfg_wide = 1'b0;
   logic [DIV_W-1:0] cfg_div = '0;
   logic [1:0] cfg_width = 2'd1;
   logic wr_valid = 1'b0;
   logic [7:0] wr_data = '0;
   logic wr_ready, tx, busy;

   int n_chk = 0, n_fail = 0;

   always #(TCK/2) clk = ~clk;

   uart_fifo_tx #(.CLK_HZ(96000), .BAUD(9600), .DIV_W(DIV_W), .DEPTH(DEPTH)) i_uart_fifo_tx (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_div(cfg_div), .cfg_width(cfg_width),
      .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
      .cfg_wide(cfg_wide), .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
      .tx(tx), .busy(busy));

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_frame(input logic [8:0] d, input int nd, input bit pe, input bit po);
      logic [15:0] r;
      int ones;
      r = '1; r[0] = 1'b0; ones = 0;
      for (int i = 0; i < nd; i++) begin
         r[1+i] = d[i];
         ones += int'(d[i]);
      end
      if (pe) r[1+nd] = po ^ ones[0];
      return r;
   endfunction

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; wr_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic set_cfg(input int div, input logic [1:0] w, input bit pe, input bit po, input bit s2, input bit wd);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_div = DIV_W'(div); cfg_width = w;
      cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2; cfg_wide = wd;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic push_byte(input logic [7:0] b);
      @(negedge clk); wr_valid = 1'b1; wr_data = b;
      while (!wr_ready) @(negedge clk);
      @(negedge clk); wr_valid = 1'b0;
   endtask

   task automatic capture(input int nb, input int div, output logic [15:0] bits, output time t0);
      bits = '1;
      @(negedge tx); t0 = $time;
      for (int i = 0; i < nb; i++) begin
         time tgt = t0 + time'((i*div + div/2)*TCK + 1);
         #(tgt - $time);
         bits[i] = tx;
      end
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   function automatic bit same(input logic [15:0] a, input logic [15:0] b, input int len);
      logic [15:0] m = 16'((32'd1 << len) - 1);
      return (a & m) == (b & m);
   endfunction

   task automatic t_reset();
      check(tx === 1'b1, "R1 tx after reset", 32'(tx), 1);
      check(busy === 1'b0, "R1 busy after reset", 32'(busy), 0);
      check(wr_ready === 1'b1, "R1 wr_ready after reset", 32'(wr_ready), 1);
   endtask

   task automatic t_default_frame();
      logic [15:0] g, e; time t0;
      fork push_byte(8'hA5); capture(10, 10, g, t0); join
      e = exp_frame(9'h0A5, 8, 0, 0);
      check(same(g, e, 10), "R2 default 8N1 frame of A5 at reset divisor (R9)", 32'(g[9:0]), 32'(e[9:0]));
      wait_idle();
      check(tx === 1'b1, "R1 line high after frame", 32'(tx), 1);
   endtask

   task automatic t_divisor();
      time t0, t1;
      set_cfg(13, 2'd1, 0, 0, 0, 0);
      fork push_byte(8'h01); begin @(negedge tx); t0 = $time; @(posedge tx); t1 = $time; end join
      check((t1 - t0) == time'(13*TCK), "R9 start bit lasts cfg_div cycles", 32'((t1-t0)/TCK), 13);
      wait_idle();
   endtask

   task automatic t_parity7();
      logic [15:0] g, e; time t0;
      set_cfg(7, 2'd0, 1, 0, 0, 0);
      fork push_byte(8'hD3); capture(10, 7, g, t0); join
      e = exp_frame(9'h053, 7, 1, 0);
      check(same(g, e, 10), "R4 R3 7-bit even parity, bit 7 ignored", 32'(g[9:0]), 32'(e[9:0]));
      wait_idle();
      set_cfg(7, 2'd0, 1, 1, 0, 0);
      fork push_byte(8'h53); capture(10, 7, g, t0); join
      e = exp_frame(9'h053, 7, 1, 1);
      check(same(g, e, 10), "R4 7-bit odd parity", 32'(g[9:0]), 32'(e[9:0]));
      wait_idle();
      set_cfg(7, 2'd3, 1, 1, 0, 0);
      fork push_byte(8'h81); capture(11, 7, g, t0); join
      e = exp_frame(9'h081, 8, 1, 1);
      check(same(g, e, 11), "R3 code 3 acts as 8-bit, odd parity", 32'(g[10:0]), 32'(e[10:0]));
      wait_idle();
   endtask

   task automatic t_two_stop();
      logic [15:0] g, e; time t0;
      set_cfg(5, 2'd1, 0, 0, 1, 0);
      fork push_byte(8'h3C); capture(11, 5, g, t0); join
      e = exp_frame(9'h03C, 8, 0, 0);
      check(same(g, e, 11), "R5 two stop bits", 32'(g[10:0]), 32'(e[10:0]));
      check(busy === 1'b1, "R12 busy during second stop bit", 32'(busy), 1);
      repeat (5) @(negedge clk);
      check(busy === 1'b0, "R12 busy low after last stop", 32'(busy), 0);
   endtask

   task automatic t_nine_plain();
      logic [15:0] g, e; time t0;
      set_cfg(6, 2'd2, 1, 0, 0, 0);
      fork push_byte(8'hFF); capture(12, 6, g, t0); join
      e = exp_frame(9'h0FF, 9, 0, 0);
      check(same(g, e, 12), "R6 9-bit plain: bit8 zero, no parity", 32'(g[11:0]), 32'(e[11:0]));
      wait_idle();
   endtask

   task automatic t_wide();
      logic [15:0] g, e; time t0;
      int lows = 0;
      set_cfg(8, 2'd2, 0, 0, 0, 1);
      push_byte(8'h3C);
      for (int k = 0; k < 40; k++) begin
         @(negedge clk);
         if (tx !== 1'b1) lows++;
      end
      check(lows == 0, "R8 single byte of a pair does not start", 32'(lows), 0);
      check(busy === 1'b1, "R12 busy while a byte waits", 32'(busy), 1);
      fork push_byte(8'hFE); capture(11, 8, g, t0); join
      e = exp_frame(9'h03C, 9, 0, 0);
      check(same(g, e, 11), "R7 pair 3C,FE gives bit8 0, upper bits ignored", 32'(g[10:0]), 32'(e[10:0]));
      wait_idle();
      fork begin push_byte(8'h81); push_byte(8'h01); end capture(11, 8, g, t0); join
      e = exp_frame(9'h181, 9, 0, 0);
      check(same(g, e, 11), "R7 pair 81,01 gives bit8 1", 32'(g[10:0]), 32'(e[10:0]));
      wait_idle();
   endtask

   task automatic t_back_to_back();
      logic [15:0] g1, g2, e1, e2; time ta, tb;
      set_cfg(6, 2'd1, 0, 0, 0, 0);
      fork
         begin push_byte(8'h0F); push_byte(8'hF0); end
         begin capture(10, 6, g1, ta); capture(10, 6, g2, tb); end
      join
      e1 = exp_frame(9'h00F, 8, 0, 0);
      e2 = exp_frame(9'h0F0, 8, 0, 0);
      check(same(g1, e1, 10), "R10 first queued frame", 32'(g1[9:0]), 32'(e1[9:0]));
      check(same(g2, e2, 10), "R10 second queued frame", 32'(g2[9:0]), 32'(e2[9:0]));
      check((tb - ta) == time'(60*TCK), "R10 no gap between frames", 32'((tb-ta)/TCK), 60);
      wait_idle();
   endtask

   task automatic t_full();
      int acc = 0;
      set_cfg(2000, 2'd1, 0, 0, 0, 0);
      @(negedge clk); wr_valid = 1'b1; wr_data = 8'h55;
      for (int k = 0; k < DEPTH + 10; k++) begin
         if (!wr_ready) break;
         acc++;
         @(negedge clk);
      end
      wr_valid = 1'b0;
      check(acc == DEPTH + 1, "R11 bytes accepted before ready drops", 32'(acc), DEPTH + 1);
      check(wr_ready === 1'b0, "R11 ready low when full", 32'(wr_ready), 0);
      check(busy === 1'b1, "R12 busy with full queue", 32'(busy), 1);
      do_reset();
      t_reset();
   endtask

   initial begin
      #(200000 * TCK);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      t_reset();
      t_default_frame();
      t_divisor();
      t_parity7();
      t_two_stop();
      t_nine_plain();
      t_wide();
      t_back_to_back();
      t_full();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule